// File: doc/BRIEF.md
# DMA Block Transfer Engine with Residual Count

This engine moves a buffer between a device-side data stream and a memory built from 16-bit words. A transfer is described by a bus address, a byte count, a direction (memory to stream, or stream to memory) and a size (bytes or words). A second mode bit picks how bus addresses reach memory. In translated mode every beat address goes out on a lookup port and comes back as a physical address. In direct mode the bus address is the physical address.

Installed memory size is a runtime input in bytes. An address is inside memory when it is strictly below that size. The two modes treat addresses past the end differently. Translated mode checks every beat and stops at the first translated address outside memory. Direct mode decides once, at start, how far the transfer may run. When the transfer ends, a one-cycle done pulse is raised and the number of bytes not moved is reported as a residual count. That value stays on its output until the next transfer completes. A byte is written to memory by reading the word, replacing one half and writing the merged word back.

Top module: `dma_blk_xfer`

## Requirements
- R1: When a start is accepted, translated mode keeps only the low 18 address bits and direct mode keeps all 22. Word transfers also clear address bit 0 and round the count down to an even value.
- R2: Byte beats step the address by 1 and word beats step it by 2. Beats run in ascending address order.
- R3: In translated mode each beat address is presented on `xl_addr` and memory is accessed at the returned `xl_pa`. The first returned address at or above `mem_size` ends the transfer before that beat touches memory or the stream. The residual is then end address minus current address.
- R4: A translated-mode transfer that runs to its end reports a residual of 0.
- R5: In direct mode, if the end address (start plus effective count) is below `mem_size`, every beat runs and the residual is 0. Otherwise, if the start address is below `mem_size`, beats run up to `mem_size` and the residual is end address minus `mem_size`.
- R6: In direct mode, if neither the end address nor the start address is below `mem_size`, no memory access and no stream transfer take place. The residual is the count exactly as given, with no even rounding.
- R7: On a byte read, an odd physical address returns memory bits 15:8 and an even one returns bits 7:0. The byte is placed on `out_data[7:0]` and bits 15:8 are zero.
- R8: A byte write reads the memory word first. It then writes back a merged word: `in_data[7:0]` goes into bits 15:8 for an odd address or bits 7:0 for an even one, and the other half is left unchanged.
- R9: Word beats move all 16 bits unchanged, in both directions, at word address `pa[21:1]`.
- R10: `out_data` stays stable while `out_valid` is high and `out_ready` is low. A stream word is taken only on a beat that is actually performed, so an ending transfer consumes no more input.
- R11: `done` is a single-cycle pulse. `residual` changes only in the cycle `done` is high. A start seen while `busy` is high is ignored. A start in the cycle `done` is high is accepted.
- R12: After reset, `busy`, `done`, `out_valid` and `mem_en` are low and `residual` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a transfer (taken when idle) |
| dir_wr | input | 1 | 1: stream to memory, 0: memory to stream |
| word_mode | input | 1 | 1: 16-bit beats, 0: byte beats |
| map_mode | input | 1 | 1: translated addresses, 0: direct |
| bus_addr | input | 22 | Start bus address |
| byte_count | input | 16 | Transfer length in bytes |
| mem_size | input | 22 | Installed memory size in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| residual | output | 16 | Bytes not transferred |
| xl_req | output | 1 | Translation lookup active |
| xl_addr | output | 18 | Bus address to translate |
| xl_pa | input | 22 | Translated physical address (same cycle) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 21 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, one cycle after the access |
| in_valid | input | 1 | Stream input valid |
| in_ready | output | 1 | Stream input accepted |
| in_data | input | 16 | Stream input data |
| out_valid | output | 1 | Stream output valid |
| out_ready | input | 1 | Stream output accepted |
| out_data | output | 16 | Stream output data |

## Verification
Two functions can fall in the same cycle: finishing one transfer (the done pulse with a fresh residual) and accepting the next start. The bench provokes this by holding `start` high during the exact cycle it sees `done`. It then checks that the old residual was reported and that the new transfer's beats match the model beat for beat. A related overlap is an early stop arriving while a stream word is already offered. That word must still be waiting when the transfer completes.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [2:0] {
    XF_IDLE,
    XF_RUN,
    XF_RDW,
    XF_OUT,
    XF_RMW
  } xfer_state_e;
endpackage

// File: rtl/dma_span_calc.sv
// Start-time span planning: trims the address, sizes the count, and sets
// the stop limit for direct mode.
module dma_span_calc #(
  parameter int PA_W  = 22,
  parameter int MAP_W = 18,
  parameter int CNT_W = 16,
  localparam int LIM_W = PA_W + 1
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             map_i,
  input  logic             word_i,
  input  logic [PA_W-1:0]  msize_i,
  output logic [LIM_W-1:0] first_o,
  output logic [LIM_W-1:0] end_o,
  output logic [LIM_W-1:0] stop_o,
  output logic             none_o
);
  localparam logic [PA_W-1:0] MAP_MASK = {{(PA_W-MAP_W){1'b0}}, {MAP_W{1'b1}}};

  logic [PA_W-1:0]  trimmed;
  logic [PA_W-1:0]  aligned;
  logic [CNT_W-1:0] eff_cnt;
  logic [LIM_W-1:0] size_ext;

  always_comb begin
    trimmed  = map_i ? (base_i & MAP_MASK) : base_i;
    aligned  = word_i ? {trimmed[PA_W-1:1], 1'b0} : trimmed;
    eff_cnt  = word_i ? {count_i[CNT_W-1:1], 1'b0} : count_i;
    first_o  = {1'b0, aligned};
    end_o    = first_o + {{(LIM_W-CNT_W){1'b0}}, eff_cnt};
    size_ext = {1'b0, msize_i};
    none_o   = 1'b0;
    if (map_i) begin
      stop_o = end_o;
    end else if (end_o < size_ext) begin
      stop_o = end_o;
    end else if (first_o < size_ext) begin
      stop_o = size_ext;
    end else begin
      stop_o = first_o;
      none_o = 1'b1;
    end
  end
endmodule

// File: rtl/dma_byte_lane.sv
// Byte steering between a 16-bit memory word and the stream.
module dma_byte_lane #(
  parameter int DATA_W = 16,
  localparam int LANE_W = DATA_W / 2
) (
  input  logic              word_i,
  input  logic              hi_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] strm_i,
  output logic [DATA_W-1:0] rd_beat_o,
  output logic [DATA_W-1:0] wr_word_o
);
  logic [LANE_W-1:0] lane;

  always_comb begin
    lane      = hi_i ? mem_word_i[DATA_W-1:LANE_W] : mem_word_i[LANE_W-1:0];
    rd_beat_o = word_i ? mem_word_i : {{LANE_W{1'b0}}, lane};
    if (word_i)
      wr_word_o = strm_i;
    else if (hi_i)
      wr_word_o = {strm_i[LANE_W-1:0], mem_word_i[LANE_W-1:0]};
    else
      wr_word_o = {mem_word_i[DATA_W-1:LANE_W], strm_i[LANE_W-1:0]};
  end
endmodule

// File: rtl/dma_blk_xfer.sv
module dma_blk_xfer
  import dma_xfer_pkg::*;
#(
  parameter int PA_W  = 22,
  parameter int MAP_W = 18,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_wr,
  input  logic             word_mode,
  input  logic             map_mode,
  input  logic [PA_W-1:0]  bus_addr,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [PA_W-1:0]  mem_size,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] residual,
  output logic             xl_req,
  output logic [MAP_W-1:0] xl_addr,
  input  logic [PA_W-1:0]  xl_pa,
  output logic             mem_en,
  output logic             mem_we,
  output logic [PA_W-2:0]  mem_addr,
  output logic [15:0]      mem_wdata,
  input  logic [15:0]      mem_rdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [15:0]      in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_data
);
  localparam int LIM_W  = PA_W + 1;
  localparam int DATA_W = 16;

  xfer_state_e      st_q, st_d;
  logic [LIM_W-1:0] cur_q, cur_d, end_q, end_d, stop_q, stop_d;
  logic [PA_W-1:0]  msz_q, msz_d, pa_q, pa_d;
  logic             wr_q, wr_d, word_q, word_d, map_q, map_d;
  logic [DATA_W-1:0] hold_q, hold_d, outd_q, outd_d;
  logic [CNT_W-1:0] res_q, res_d;
  logic             done_q, done_d;

  logic [LIM_W-1:0] sp_first, sp_end, sp_stop;
  logic             sp_none;
  logic [PA_W-1:0]  beat_pa;
  logic [LIM_W-1:0] step, diff_stop, diff_cur;
  logic [DATA_W-1:0] lane_rd, lane_wr;

  dma_span_calc #(.PA_W(PA_W), .MAP_W(MAP_W), .CNT_W(CNT_W)) u_span (
    .base_i  (bus_addr),
    .count_i (byte_count),
    .map_i   (map_mode),
    .word_i  (word_mode),
    .msize_i (mem_size),
    .first_o (sp_first),
    .end_o   (sp_end),
    .stop_o  (sp_stop),
    .none_o  (sp_none)
  );

  dma_byte_lane #(.DATA_W(DATA_W)) u_lane (
    .word_i     (word_q),
    .hi_i       (pa_q[0]),
    .mem_word_i (mem_rdata),
    .strm_i     (hold_q),
    .rd_beat_o  (lane_rd),
    .wr_word_o  (lane_wr)
  );

  assign beat_pa   = map_q ? xl_pa : cur_q[PA_W-1:0];
  assign step      = word_q ? LIM_W'(2) : LIM_W'(1);
  assign diff_stop = end_q - stop_q;
  assign diff_cur  = end_q - cur_q;
  assign xl_addr   = cur_q[MAP_W-1:0];
  assign busy      = (st_q != XF_IDLE);
  assign done      = done_q;
  assign residual  = res_q;
  assign out_data  = outd_q;

  always_comb begin
    st_d = st_q;  cur_d = cur_q;  end_d = end_q;  stop_d = stop_q;
    msz_d = msz_q;  pa_d = pa_q;  wr_d = wr_q;  word_d = word_q;  map_d = map_q;
    hold_d = hold_q;  outd_d = outd_q;  res_d = res_q;  done_d = 1'b0;
    mem_en = 1'b0;  mem_we = 1'b0;  mem_addr = pa_q[PA_W-1:1];  mem_wdata = lane_wr;
    in_ready = 1'b0;  out_valid = 1'b0;  xl_req = 1'b0;
    unique case (st_q)
      XF_IDLE: begin
        if (start) begin
          cur_d  = sp_first;  end_d = sp_end;  stop_d = sp_stop;  msz_d = mem_size;
          wr_d   = dir_wr;  word_d = word_mode;  map_d = map_mode;
          if (sp_none) begin
            res_d  = byte_count;
            done_d = 1'b1;
          end else begin
            st_d = XF_RUN;
          end
        end
      end
      XF_RUN: begin
        if (cur_q >= stop_q) begin
          res_d  = diff_stop[CNT_W-1:0];
          done_d = 1'b1;
          st_d   = XF_IDLE;
        end else begin
          xl_req = map_q;
          if (map_q && (beat_pa >= msz_q)) begin
            res_d  = diff_cur[CNT_W-1:0];
            done_d = 1'b1;
            st_d   = XF_IDLE;
          end else if (!wr_q) begin
            mem_en   = 1'b1;
            mem_addr = beat_pa[PA_W-1:1];
            pa_d     = beat_pa;
            st_d     = XF_RDW;
          end else if (in_valid) begin
            in_ready = 1'b1;
            mem_en   = 1'b1;
            mem_addr = beat_pa[PA_W-1:1];
            if (word_q) begin
              mem_we    = 1'b1;
              mem_wdata = in_data;
              cur_d     = cur_q + step;
            end else begin
              pa_d   = beat_pa;
              hold_d = in_data;
              st_d   = XF_RMW;
            end
          end
        end
      end
      XF_RDW: begin
        outd_d = lane_rd;
        st_d   = XF_OUT;
      end
      XF_OUT: begin
        out_valid = 1'b1;
        if (out_ready) begin
          cur_d = cur_q + step;
          st_d  = XF_RUN;
        end
      end
      XF_RMW: begin
        mem_en = 1'b1;
        mem_we = 1'b1;
        cur_d  = cur_q + step;
        st_d   = XF_RUN;
      end
      default: st_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= XF_IDLE;  cur_q <= '0;  end_q <= '0;  stop_q <= '0;
      msz_q <= '0;  pa_q <= '0;  wr_q <= 1'b0;  word_q <= 1'b0;  map_q <= 1'b0;
      hold_q <= '0;  outd_q <= '0;  res_q <= '0;  done_q <= 1'b0;
    end else begin
      st_q <= st_d;  cur_q <= cur_d;  end_q <= end_d;  stop_q <= stop_d;
      msz_q <= msz_d;  pa_q <= pa_d;  wr_q <= wr_d;  word_q <= word_d;  map_q <= map_d;
      hold_q <= hold_d;  outd_q <= outd_d;  res_q <= res_d;  done_q <= done_d;
    end
  end

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11
  resid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done) |-> $stable(residual));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  mem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> ({1'b0, mem_addr, 1'b0} < {1'b0, msz_q}));

  // R8
  rmw_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !word_q) |-> $past(mem_en && !mem_we));
endmodule

// File: tb/sim_dma_blk_xfer.sv
module sim_dma_blk_xfer;
  localparam int XOFF = 'h10000;

  logic clk = 1'b0;
  logic rst_n;
  logic start, dir_wr, word_mode, map_mode;
  logic [21:0] bus_addr, mem_size, xl_pa;
  logic [15:0] byte_count, residual, mem_wdata, mem_rdata, in_data, out_data;
  logic busy, done, xl_req, mem_en, mem_we, in_valid, in_ready, out_valid, out_ready;
  logic [17:0] xl_addr;
  logic [20:0] mem_addr;

  int nchk = 0, nfail = 0, cyc = 0, dseed = 1;
  logic [15:0] bmem[int];
  logic [15:0] smem[int];
  logic [15:0] exp_out[$];
  logic [15:0] in_q[$];
  logic [36:0] exp_wr[$];

  always #5 clk = ~clk;

  dma_blk_xfer u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr), .word_mode(word_mode),
    .map_mode(map_mode), .bus_addr(bus_addr), .byte_count(byte_count), .mem_size(mem_size),
    .busy(busy), .done(done), .residual(residual), .xl_req(xl_req), .xl_addr(xl_addr),
    .xl_pa(xl_pa), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  assign xl_pa = 22'(xl_addr) + 22'(XOFF);

  function automatic logic [15:0] initw(int a);
    return 16'(a * 40503) ^ 16'h5AC3;
  endfunction
  function automatic logic [15:0] brd(int a);
    if (bmem.exists(a)) return bmem[a];
    return initw(a);
  endfunction
  function automatic logic [15:0] srd(int a);
    if (smem.exists(a)) return smem[a];
    return initw(a);
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= brd(int'(mem_addr));
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // stream drive and per-clock comparison against the model queues
  always @(negedge clk) begin
    cyc++;
    out_ready = (cyc % 3) != 1;
    in_valid  = (in_q.size() > 0) && ((cyc % 4) != 2);
    in_data   = (in_q.size() > 0) ? in_q[0] : 16'h0;
    #1;
    if (rst_n === 1'b1) begin
      if (out_valid && out_ready) begin
        if (exp_out.size() == 0) check(1'b0, "R10 extra output", out_data, 0);
        else begin
          logic [15:0] e;
          e = exp_out.pop_front();
          check(out_data == e, "R7/R9 read beat", out_data, e);
        end
      end
      if (in_valid && in_ready) void'(in_q.pop_front());
      if (mem_en && mem_we) begin
        if (exp_wr.size() == 0) check(1'b0, "R6/R10 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [36:0] w;
          w = exp_wr.pop_front();
          check({mem_addr, mem_wdata} == w, "R8/R9 write beat", {mem_addr, mem_wdata}, w);
        end
      end
    end
    if (cyc > 60000) begin
      check(1'b0, "watchdog", cyc, 0);
      finish_run();
    end
  end

  // behavioural model: expected beats and residual
  task automatic plan(input int addr, cnt, input bit wr, wd, mp, input int msz, output int res);
    int ba, ce, lim, stop, stp, pa;
    logic [15:0] w, d, m;
    ba = mp ? (addr & 'h3FFFF) : (addr & 'h3FFFFF);
    if (wd) ba = ba & ~1;
    ce  = wd ? (cnt & ~1) : cnt;
    lim = ba + ce;
    stp = wd ? 2 : 1;
    if (mp) stop = lim;
    else if (lim < msz) stop = lim;
    else if (ba < msz) stop = msz;
    else begin res = cnt; return; end
    res = lim - stop;
    for (int cur = ba; cur < stop; cur += stp) begin
      pa = mp ? ((cur & 'h3FFFF) + XOFF) : cur;
      if (mp && pa >= msz) begin res = lim - cur; return; end
      w = srd(pa >> 1);
      if (!wr) begin
        exp_out.push_back(wd ? w : ((pa & 1) ? {8'h0, w[15:8]} : {8'h0, w[7:0]}));
      end else begin
        d = 16'(dseed * 'h1357 + 'h2468);
        dseed++;
        in_q.push_back(d);
        m = wd ? d : ((pa & 1) ? {d[7:0], w[7:0]} : {w[15:8], d[7:0]});
        smem[pa >> 1] = m;
        exp_wr.push_back({21'(pa >> 1), m});
      end
    end
  endtask

  task automatic run_job(input int addr, cnt, input bit wr, wd, mp, input int msz,
                         input bit chain, tail, poke, input int extra, input string req);
    int res, guard;
    logic [15:0] held;
    plan(addr, cnt, wr, wd, mp, msz, res);
    for (int k = 0; k < extra; k++) in_q.push_back(16'hBEEF);
    if (!chain) @(negedge clk);
    bus_addr = 22'(addr); byte_count = 16'(cnt); dir_wr = wr; word_mode = wd;
    map_mode = mp; mem_size = 22'(msz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 3) begin
        start = 1'b1; bus_addr = 22'h000600; dir_wr = ~wr;
      end else if (poke && guard == 4) start = 1'b0;
    end
    check(done == 1'b1, "R11 done seen", done, 1);
    check(residual == 16'(res), req, residual, res);
    check(exp_out.size() == 0 && exp_wr.size() == 0, "R2 all beats", exp_out.size() + exp_wr.size(), 0);
    check(in_q.size() == extra, "R10 stream consumption", in_q.size(), extra);
    if (tail) begin
      in_q.delete();
      held = residual;
      @(negedge clk);
      check(done == 1'b0, "R11 single pulse", done, 0);
      @(negedge clk); @(negedge clk);
      check(residual == held, "R11 residual held", residual, held);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dir_wr = 1'b0; word_mode = 1'b0; map_mode = 1'b0;
    bus_addr = '0; byte_count = '0; mem_size = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(busy == 1'b0, "R12 busy", busy, 0);
    check(done == 1'b0, "R12 done", done, 0);
    check(residual == 16'h0, "R12 residual", residual, 0);
    check(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
    check(mem_en == 1'b0, "R12 mem_en", mem_en, 0);
    // R7 direct byte read, odd count
    run_job('h100, 5, 0, 0, 0, 'h200000, 0, 1, 0, 0, "R7 R5 residual");
    // R1 R9 direct word read, odd start and count
    run_job('h203, 7, 0, 1, 0, 'h200000, 0, 1, 0, 0, "R1 R9 residual");
    // R8 direct byte write from an odd address
    run_job('h301, 4, 1, 0, 0, 'h200000, 0, 1, 0, 0, "R8 residual");
    // R9 direct word write
    run_job('h400, 6, 1, 1, 0, 'h200000, 0, 1, 0, 0, "R9 residual");
    // R5 direct truncation at memory size
    run_job('h1000, 'h10, 0, 0, 0, 'h1008, 0, 1, 0, 0, "R5 truncated residual");
    // R6 direct, nothing in memory, count not rounded
    run_job('h2000, 9, 1, 1, 0, 'h1008, 0, 1, 0, 0, "R6 full residual");
    // R1 R3 R4 translated byte read, upper bits trimmed
    run_job('h3C0050, 6, 0, 0, 1, 'h200000, 0, 1, 0, 0, "R4 translated residual");
    // R3 translated abort with a word left waiting on the stream
    run_job('h50, 'h10, 1, 0, 1, 'h10058, 0, 1, 0, 1, "R3 abort residual");
    // R3 R9 translated word write
    run_job('h2001, 5, 1, 1, 1, 'h200000, 0, 1, 0, 0, "R3 R4 word residual");
    // R11 start while busy is ignored
    run_job('h500, 6, 0, 0, 0, 'h200000, 0, 1, 1, 0, "R11 busy start residual");
    // R2 zero count
    run_job('h700, 0, 1, 0, 0, 'h200000, 0, 1, 0, 0, "R2 zero count residual");
    // R11 start in the done cycle
    run_job('h800, 4, 0, 1, 0, 'h200000, 0, 0, 0, 0, "R11 first residual");
    run_job('h900, 3, 1, 0, 0, 'h200000, 1, 1, 0, 0, "R11 chained residual");
    // R5 direct truncation with writes
    run_job('hFFE, 8, 1, 0, 0, 'h1001, 0, 1, 0, 0, "R5 write truncated residual");
    finish_run();
  end
endmodule